// File: doc/BRIEF.md
# Multiprocessor Interrupt Router

This block collects thirty-two level-type system interrupt lines and one local timer line per processor. It keeps a record of them in a shared system pending word. A disable word masks sources one by one, and its top bit shuts off all routing at once. Sources that are pending and enabled go to a single selected target processor. There, a fixed bit-to-level table turns each source bit into one of sixteen processor interrupt levels.

Each processor also owns a pending word. Its upper bits hold software interrupts, which software sets and clears. Those bits are merged into that processor's level vector whether or not it is the target. The routing table also sets the lower bits of this word when hardware events arrive.

Software reaches the block through a word-addressed write/read port with two windows. One window holds the system registers. The other gives each processor its own 4 KB page, and the processor number comes from the address bits above the page offset. Reads are combinational. Every level output is registered.

Top module: `irq_router`

## Requirements
- R1: After reset, every pending word reads zero and the target is processor 0. The disable word is loaded with 0x0FA2007F, so its masked readback is zero. All level outputs are zero.
- R2: When external line i rises, system pending bit i is set. The current target's pending word also gets bit MAP[i] set. When line i falls, both bits are cleared. The default map sends source j to level (j mod 15)+1.
- R3: When processor c's timer line rises, system bit TIMER_BIT (default 19) is set, along with bit MAP[TIMER_BIT] of processor c's own pending word. A fall clears both.
- R4: In the system window, the register index is address bits [4:2]. Index 0 reads the system pending word with bit 31 forced to 0. Index 1 reads the disable word ANDed with the valid mask ~0x0FA2007F. Any other index reads zero, and so does any processor-window index other than 0.
- R5: A write to system index 2 clears the disable bits named in the data, after masking with the valid mask. The reserved bits (set in 0x0FA2007F) stay disabled, so a source on a reserved bit never reaches a level output.
- R6: A write to system index 3 sets the named valid disable bits and clears the same bits in the system pending word. A disabled source that is still pending produces no level.
- R7: A write to system index 4 sets the target to the data ANDed with NUM_CPU-1. Hardware events arriving after that are recorded in the new target's pending word, and routing goes to it.
- R8: While disable bit 31 is set, no processor receives any routed hardware level.
- R9: The target's level vector contains bit MAP[j] for every bit j that is pending and not disabled. This happens only when at least one such bit exists. A processor that is not the target gets no routed levels.
- R10: In the processor window (processor = address bits [12 and up], index = bits [3:2]), index 0 reads that processor's pending word. A write to index 2 ORs (data AND 0xFFFE0000) into it. A write to index 1 clears (data AND 0xFFFE0000) from it, and before masking, data bit 14 also selects bit 31.
- R11: Pending bits 31..17 of every processor appear on its level outputs 15..1.
- R12: Each level output changes exactly one clock after the register change that causes it.
- R13: Within one clock, input line events are applied first and a bus write after them. Among the line events, a set wins over a clear on the same bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_irq | input | 32 | External system interrupt lines |
| tmr_irq | input | NUM_CPU | Local timer line per processor |
| bus_wr | input | 1 | Write strobe for one clock |
| bus_win_sys | input | 1 | 1 selects the system window, 0 the processor pages |
| bus_addr | input | 12+log2(NUM_CPU) | Byte address inside the selected window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data |
| cpu_level | output | NUM_CPU*16 | Registered level vector, 16 bits per processor, processor 0 in the low bits |

## Verification
The routing path is driven first with single source edges, so that each source bit's map to a level and the choice of processor can each be seen alone. Several sources are then pending at once, and the global and per-source disables are switched around them. This separates the per-source mask from the global cut-off and from the disable-clears-pending side effect. Software words are written with all ones and with a lone bit 14, which tells the 0xFFFE0000 mask apart from the bit 14 to bit 31 alias. Random stretches then toggle many lines, move the target, and mix in writes during the same clock as line edges, which tests the fixed order of updates.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;

  localparam int SRC_N  = 32;
  localparam int DATA_W = 32;
  localparam int LVL_N  = 16;
  localparam int LVL_W  = 4;
  localparam int PAGE_W = 12;

  localparam logic [DATA_W-1:0] SYS_RSVD  = 32'h0FA2_007F;
  localparam logic [DATA_W-1:0] SYS_VALID = ~SYS_RSVD;
  localparam logic [DATA_W-1:0] SOFT_MASK = 32'hFFFE_0000;
  localparam int GDIS_BIT       = 31;
  localparam int SOFT_ALIAS_BIT = 14;

  // system window register indices
  localparam logic [2:0] SYS_RD_PEND = 3'd0;
  localparam logic [2:0] SYS_RD_DIS  = 3'd1;
  localparam logic [2:0] SYS_WR_EN   = 3'd2;
  localparam logic [2:0] SYS_WR_DIS  = 3'd3;
  localparam logic [2:0] SYS_WR_TGT  = 3'd4;

  // processor window register indices
  localparam logic [1:0] CPU_PEND     = 2'd0;
  localparam logic [1:0] CPU_SOFT_CLR = 2'd1;
  localparam logic [1:0] CPU_SOFT_SET = 2'd2;

  typedef logic [SRC_N-1:0][LVL_W-1:0] lvl_map_t;

  function automatic lvl_map_t default_level_map();
    lvl_map_t m;
    for (int j = 0; j < SRC_N; j++) m[j] = LVL_W'((j % 15) + 1);
    return m;
  endfunction

  function automatic logic [DATA_W-1:0] level_bit(input logic [LVL_W-1:0] l);
    return DATA_W'(1) << l;
  endfunction

  function automatic logic [DATA_W-1:0] soft_clear_bits(input logic [DATA_W-1:0] w);
    logic [DATA_W-1:0] v;
    v = w;
    if (w[SOFT_ALIAS_BIT]) v[DATA_W-1] = 1'b1;
    return v & SOFT_MASK;
  endfunction

  function automatic logic [LVL_N-1:0] map_to_levels(input logic [SRC_N-1:0] bits,
                                                     input lvl_map_t map);
    logic [LVL_N-1:0] r;
    r = '0;
    for (int j = 0; j < SRC_N; j++)
      if (bits[j]) r = r | (LVL_N'(1) << map[j]);
    return r;
  endfunction

endpackage

// File: rtl/irq_edge_det.sv
module irq_edge_det #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl_i,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);
  logic [W-1:0] lvl_q;

  always_ff @(posedge clk) begin
    if (!rst_n) lvl_q <= '0;
    else        lvl_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~lvl_q;
  assign fall_o = ~lvl_i & lvl_q;
endmodule

// File: rtl/irq_level_route.sv
module irq_level_route import irq_router_pkg::*; #(
  parameter lvl_map_t LVL_MAP = default_level_map()
) (
  input  logic [DATA_W-1:0] sys_pend_i,
  input  logic [DATA_W-1:0] sys_dis_i,
  input  logic              is_target_i,
  input  logic [DATA_W-1:0] cpu_pend_i,
  output logic [LVL_N-1:0]  hw_lvl_o,
  output logic [LVL_N-1:0]  lvl_next_o
);
  logic [DATA_W-1:0] enabled;
  logic              route_on;
  logic              unused_low;

  assign enabled    = sys_pend_i & ~sys_dis_i;
  assign route_on   = is_target_i && (|enabled) && !sys_dis_i[GDIS_BIT];
  assign hw_lvl_o   = route_on ? map_to_levels(enabled, LVL_MAP) : '0;
  assign lvl_next_o = hw_lvl_o | {cpu_pend_i[DATA_W-1:17], 1'b0};
  assign unused_low = ^cpu_pend_i[16:0];
endmodule

// File: rtl/irq_router.sv
module irq_router import irq_router_pkg::*; #(
  parameter int       NUM_CPU   = 4,
  parameter int       TIMER_BIT = 19,
  parameter lvl_map_t LVL_MAP   = default_level_map()
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [SRC_N-1:0]                  ext_irq,
  input  logic [NUM_CPU-1:0]                tmr_irq,
  input  logic                              bus_wr,
  input  logic                              bus_win_sys,
  input  logic [PAGE_W+$clog2(NUM_CPU)-1:0] bus_addr,
  input  logic [DATA_W-1:0]                 bus_wdata,
  output logic [DATA_W-1:0]                 bus_rdata,
  output logic [NUM_CPU*LVL_N-1:0]          cpu_level
);
  localparam int CPU_W = $clog2(NUM_CPU);

  // state
  logic [DATA_W-1:0]               sys_q, dis_q;
  logic [CPU_W-1:0]                tgt_q;
  logic [NUM_CPU-1:0][DATA_W-1:0]  cpu_q;
  logic [NUM_CPU-1:0][LVL_N-1:0]   lvl_q;

  // next state and events
  logic [DATA_W-1:0]               sys_nxt, dis_nxt;
  logic [CPU_W-1:0]                tgt_nxt;
  logic [NUM_CPU-1:0][DATA_W-1:0]  cpu_nxt, cpu_set, cpu_clr;
  logic [DATA_W-1:0]               sys_set, sys_clr;
  logic [SRC_N-1:0]                ext_rise, ext_fall;
  logic [NUM_CPU-1:0]              tmr_rise, tmr_fall;
  logic                            tmr_rise_any;
  logic [NUM_CPU-1:0][LVL_N-1:0]   hw_lvl, lvl_nxt;
  logic [NUM_CPU*LVL_N-1:0]        hw_lvl_all;

  // bus decode
  logic [2:0]        sys_idx;
  logic [1:0]        cpu_idx;
  logic [CPU_W-1:0]  cpu_sel;
  logic [DATA_W-1:0] wv;
  logic              sys_wr_en, sys_wr_dis, sys_wr_tgt;
  logic              cpu_wr_clr, cpu_wr_set;
  logic              rd_sys_pend;
  logic              unused_addr;

  assign sys_idx     = bus_addr[4:2];
  assign cpu_idx     = bus_addr[3:2];
  assign cpu_sel     = bus_addr[PAGE_W +: CPU_W];
  assign wv          = bus_wdata & SYS_VALID;
  assign sys_wr_en   = bus_wr &  bus_win_sys & (sys_idx == SYS_WR_EN);
  assign sys_wr_dis  = bus_wr &  bus_win_sys & (sys_idx == SYS_WR_DIS);
  assign sys_wr_tgt  = bus_wr &  bus_win_sys & (sys_idx == SYS_WR_TGT);
  assign cpu_wr_clr  = bus_wr & ~bus_win_sys & (cpu_idx == CPU_SOFT_CLR);
  assign cpu_wr_set  = bus_wr & ~bus_win_sys & (cpu_idx == CPU_SOFT_SET);
  assign rd_sys_pend = bus_win_sys && (sys_idx == SYS_RD_PEND);
  assign unused_addr = ^{bus_addr[PAGE_W-1:5], bus_addr[1:0]};

  irq_edge_det #(.W(SRC_N)) u_ext_edge (
    .clk(clk), .rst_n(rst_n), .lvl_i(ext_irq), .rise_o(ext_rise), .fall_o(ext_fall)
  );

  irq_edge_det #(.W(NUM_CPU)) u_tmr_edge (
    .clk(clk), .rst_n(rst_n), .lvl_i(tmr_irq), .rise_o(tmr_rise), .fall_o(tmr_fall)
  );

  assign tmr_rise_any = |tmr_rise;

  // line events: set and clear masks
  always_comb begin
    sys_set = ext_rise;
    sys_clr = ext_fall;
    if (|tmr_rise) sys_set[TIMER_BIT] = 1'b1;
    if (|tmr_fall) sys_clr[TIMER_BIT] = 1'b1;
    cpu_set = '0;
    cpu_clr = '0;
    for (int j = 0; j < SRC_N; j++) begin
      if (ext_rise[j]) cpu_set[tgt_q] = cpu_set[tgt_q] | level_bit(LVL_MAP[j]);
      if (ext_fall[j]) cpu_clr[tgt_q] = cpu_clr[tgt_q] | level_bit(LVL_MAP[j]);
    end
    for (int c = 0; c < NUM_CPU; c++) begin
      if (tmr_rise[c]) cpu_set[c] = cpu_set[c] | level_bit(LVL_MAP[TIMER_BIT]);
      if (tmr_fall[c]) cpu_clr[c] = cpu_clr[c] | level_bit(LVL_MAP[TIMER_BIT]);
    end
  end

  // next state: line events first, bus write after
  always_comb begin
    sys_nxt = (sys_q & ~sys_clr) | sys_set;
    dis_nxt = dis_q;
    tgt_nxt = tgt_q;
    if (sys_wr_en)  dis_nxt = dis_q & ~wv;
    if (sys_wr_dis) begin
      dis_nxt = dis_q | wv;
      sys_nxt = sys_nxt & ~wv;
    end
    if (sys_wr_tgt) tgt_nxt = bus_wdata[CPU_W-1:0];
    for (int c = 0; c < NUM_CPU; c++) begin
      cpu_nxt[c] = (cpu_q[c] & ~cpu_clr[c]) | cpu_set[c];
      if (cpu_wr_clr && cpu_sel == CPU_W'(c))
        cpu_nxt[c] = cpu_nxt[c] & ~soft_clear_bits(bus_wdata);
      if (cpu_wr_set && cpu_sel == CPU_W'(c))
        cpu_nxt[c] = cpu_nxt[c] | (bus_wdata & SOFT_MASK);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sys_q <= '0;
      dis_q <= SYS_RSVD;
      tgt_q <= '0;
      cpu_q <= '0;
    end else begin
      sys_q <= sys_nxt;
      dis_q <= dis_nxt;
      tgt_q <= tgt_nxt;
      cpu_q <= cpu_nxt;
    end
  end

  // per-processor level routing
  for (genvar g = 0; g < NUM_CPU; g++) begin : g_route
    irq_level_route #(.LVL_MAP(LVL_MAP)) u_route (
      .sys_pend_i (sys_q),
      .sys_dis_i  (dis_q),
      .is_target_i(tgt_q == CPU_W'(g)),
      .cpu_pend_i (cpu_q[g]),
      .hw_lvl_o   (hw_lvl[g]),
      .lvl_next_o (lvl_nxt[g])
    );

    always_ff @(posedge clk) begin
      if (!rst_n) lvl_q[g] <= '0;
      else        lvl_q[g] <= lvl_nxt[g];
    end

    assign cpu_level[g*LVL_N +: LVL_N] = lvl_q[g];
  end

  assign hw_lvl_all = hw_lvl;

  // read mux
  always_comb begin
    bus_rdata = '0;
    if (bus_win_sys) begin
      case (sys_idx)
        SYS_RD_PEND: bus_rdata = sys_q & ~(DATA_W'(1) << GDIS_BIT);
        SYS_RD_DIS:  bus_rdata = dis_q & SYS_VALID;
        default:     bus_rdata = '0;
      endcase
    end else if (cpu_idx == CPU_PEND) begin
      bus_rdata = cpu_q[cpu_sel];
    end
  end
endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk import irq_router_pkg::*; #(
  parameter int NUM_CPU = 4,
  parameter int CPU_W   = 2
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     sys_wr_dis,
  input logic                     sys_wr_tgt,
  input logic                     rd_sys_pend,
  input logic                     tmr_rise_any,
  input logic [SRC_N-1:0]         ext_rise,
  input logic [SRC_N-1:0]         ext_fall,
  input logic [DATA_W-1:0]        bus_wdata,
  input logic [DATA_W-1:0]        bus_rdata,
  input logic [DATA_W-1:0]        sys_q,
  input logic [DATA_W-1:0]        dis_q,
  input logic [CPU_W-1:0]         tgt_q,
  input logic [NUM_CPU*LVL_N-1:0] hw_lvl_all
);
  // R2: a rising line is recorded unless a disable write hides it
  p_rise_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(sys_wr_dis)) |-> ((sys_q & $past(ext_rise)) == $past(ext_rise)));

  // R2: a falling line clears its pending bit unless a timer sets one
  p_fall_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(tmr_rise_any)) |-> ((sys_q & $past(ext_fall)) == '0));

  // R4: pending readback never shows bit 31
  p_rd_bit31_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_sys_pend |-> !bus_rdata[GDIS_BIT]);

  // R5: reserved disable bits remain set
  p_rsvd_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (dis_q & SYS_RSVD) == SYS_RSVD);

  // R6: disabling clears the matching pending bits
  p_dis_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(sys_wr_dis)) |-> ((sys_q & $past(bus_wdata) & SYS_VALID) == '0));

  // R7: target follows the masked write
  p_tgt_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(sys_wr_tgt)) |-> (tgt_q == $past(bus_wdata[CPU_W-1:0])));

  // R8: global disable removes every routed level
  p_gdis_block_r8: assert property (@(posedge clk) disable iff (!rst_n)
    dis_q[GDIS_BIT] |-> (hw_lvl_all == '0));

  // R9: at most one processor receives routed levels
  p_one_target_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_lvl_all & ~({{(NUM_CPU-1)*LVL_N{1'b0}}, {LVL_N{1'b1}}} << (tgt_q * LVL_N))) == '0);
endmodule

bind irq_router irq_router_chk #(.NUM_CPU(NUM_CPU), .CPU_W(CPU_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sys_wr_dis(sys_wr_dis), .sys_wr_tgt(sys_wr_tgt),
  .rd_sys_pend(rd_sys_pend), .tmr_rise_any(tmr_rise_any), .ext_rise(ext_rise),
  .ext_fall(ext_fall), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sys_q(sys_q),
  .dis_q(dis_q), .tgt_q(tgt_q), .hw_lvl_all(hw_lvl_all)
);

// File: tb/irq_router_tb.sv
module irq_router_tb_top;
  import irq_router_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int NC = 4;
  localparam int TB = 19;
  localparam int AW = PAGE_W + 2;

  logic          clk, rst_n;
  logic [31:0]   ext_irq;
  logic [NC-1:0] tmr_irq;
  logic          bus_wr, bus_win_sys;
  logic [AW-1:0] bus_addr;
  logic [31:0]   bus_wdata, bus_rdata;
  logic [NC*16-1:0] cpu_level;

  irq_router #(.NUM_CPU(NC), .TIMER_BIT(TB)) dut_i (
    .clk(clk), .rst_n(rst_n), .ext_irq(ext_irq), .tmr_irq(tmr_irq),
    .bus_wr(bus_wr), .bus_win_sys(bus_win_sys), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cpu_level(cpu_level)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  // reference state
  logic [31:0]   m_sys, m_dis, m_ext;
  logic [31:0]   m_cpu [NC];
  logic [NC-1:0] m_tmr;
  int            m_tgt;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic int tb_map(input int j);
    return (j % 15) + 1;
  endfunction

  function automatic logic [15:0] exp_level(input int c);
    logic [31:0] en;
    logic [15:0] r;
    en = m_sys & ~m_dis;
    r = 16'h0;
    if (c == m_tgt && en != 0 && !m_dis[31])
      for (int l = 0; l < 16; l++)
        for (int j = 0; j < 32; j++)
          if (en[j] && tb_map(j) == l) r[l] = 1'b1;
    r = r | (m_cpu[c][31:16] & 16'hFFFE);
    return r;
  endfunction

  function automatic logic [AW-1:0] sys_a(input int idx);
    return AW'(idx << 2);
  endfunction

  function automatic logic [AW-1:0] cpu_a(input int c, input int idx);
    return AW'((c << 12) | (idx << 2));
  endfunction

  task automatic model_apply(input logic [31:0] e, input logic [NC-1:0] t, input bit w,
                             input bit ws, input logic [AW-1:0] a, input logic [31:0] d);
    logic [31:0] sset, sclr, v;
    logic [31:0] cset [NC];
    logic [31:0] cclr [NC];
    int c;
    sset = 0; sclr = 0;
    for (int k = 0; k < NC; k++) begin cset[k] = 0; cclr[k] = 0; end
    for (int j = 0; j < 32; j++) begin
      if (e[j] && !m_ext[j]) begin sset[j] = 1; cset[m_tgt][tb_map(j)] = 1; end
      if (!e[j] && m_ext[j]) begin sclr[j] = 1; cclr[m_tgt][tb_map(j)] = 1; end
    end
    for (int k = 0; k < NC; k++) begin
      if (t[k] && !m_tmr[k]) begin sset[TB] = 1; cset[k][tb_map(TB)] = 1; end
      if (!t[k] && m_tmr[k]) begin sclr[TB] = 1; cclr[k][tb_map(TB)] = 1; end
    end
    m_sys = (m_sys & ~sclr) | sset;
    for (int k = 0; k < NC; k++) m_cpu[k] = (m_cpu[k] & ~cclr[k]) | cset[k];
    m_ext = e;
    m_tmr = t;
    if (w) begin
      if (ws) begin
        v = d & ~32'h0FA2007F;
        case (a[4:2])
          3'd2: m_dis = m_dis & ~v;
          3'd3: begin m_dis = m_dis | v; m_sys = m_sys & ~v; end
          3'd4: m_tgt = int'(d % NC);
          default: ;
        endcase
      end else begin
        c = int'(a[13:12]);
        if (a[3:2] == 2'd1) begin
          v = d;
          if (d[14]) v[31] = 1'b1;
          m_cpu[c] = m_cpu[c] & ~(v & 32'hFFFE0000);
        end else if (a[3:2] == 2'd2) begin
          m_cpu[c] = m_cpu[c] | (d & 32'hFFFE0000);
        end
      end
    end
  endtask

  task automatic cyc(input logic [31:0] e, input logic [NC-1:0] t, input bit w = 0,
                     input bit ws = 0, input logic [AW-1:0] a = '0, input logic [31:0] d = '0);
    @(negedge clk);
    ext_irq = e; tmr_irq = t; bus_wr = w; bus_win_sys = ws; bus_addr = a; bus_wdata = d;
    model_apply(e, t, w, ws, a, d);
    @(posedge clk);
    #1;
    bus_wr = 1'b0;
  endtask

  task automatic rd(input bit ws, input logic [AW-1:0] a, output logic [31:0] v);
    bus_win_sys = ws; bus_addr = a;
    #1;
    v = bus_rdata;
  endtask

  task automatic check_all(input string req);
    logic [31:0] v;
    @(posedge clk);
    #1;
    for (int c = 0; c < NC; c++)
      chk(cpu_level[c*16 +: 16] == exp_level(c), req, 32'(cpu_level[c*16 +: 16]), 32'(exp_level(c)));
    rd(1, sys_a(0), v); chk(v == (m_sys & 32'h7FFFFFFF), req, v, m_sys & 32'h7FFFFFFF);
    rd(1, sys_a(1), v); chk(v == (m_dis & ~32'h0FA2007F), req, v, m_dis & ~32'h0FA2007F);
    for (int c = 0; c < NC; c++) begin
      rd(0, cpu_a(c, 0), v); chk(v == m_cpu[c], req, v, m_cpu[c]);
    end
  endtask

  function automatic logic [15:0] lvl(input int c);
    return cpu_level[c*16 +: 16];
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL all watchdog act=%h exp=%h", 32'd0, 32'd1);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, e;
    logic [NC-1:0] t;
    void'($urandom(32'd4242));
    rst_n = 0; ext_irq = 0; tmr_irq = 0; bus_wr = 0; bus_win_sys = 0; bus_addr = 0; bus_wdata = 0;
    m_sys = 0; m_dis = 32'h0FA2007F; m_ext = 0; m_tmr = 0; m_tgt = 0;
    for (int k = 0; k < NC; k++) m_cpu[k] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;

    // R1 reset state
    check_all("R1");
    rd(1, sys_a(1), v); chk(v == 0, "R1", v, 0);

    // R2 single source rise on target 0
    cyc(32'h100, 0);
    check_all("R2");
    rd(1, sys_a(0), v); chk(v == 32'h100, "R2", v, 32'h100);
    chk(lvl(0) == 16'h0200, "R2", 32'(lvl(0)), 32'h0200);

    // R12 soft set on cpu1: level one clock late
    cyc(32'h100, 0, 1, 0, cpu_a(1, 2), 32'h0010_0000);
    chk(lvl(1) == 16'h0, "R12", 32'(lvl(1)), 0);
    @(posedge clk); #1;
    chk(lvl(1) == 16'h0010, "R12", 32'(lvl(1)), 32'h0010);

    // R10 R11 all-ones soft set on cpu2, then bit14 alias clear
    cyc(32'h100, 0, 1, 0, cpu_a(2, 2), 32'hFFFF_FFFF);
    check_all("R11");
    rd(0, cpu_a(2, 0), v); chk(v == 32'hFFFE_0000, "R10", v, 32'hFFFE_0000);
    chk(lvl(2) == 16'hFFFE, "R11", 32'(lvl(2)), 32'hFFFE);
    cyc(32'h100, 0, 1, 0, cpu_a(2, 1), 32'h0000_4000);
    check_all("R10");
    rd(0, cpu_a(2, 0), v); chk(v == 32'h7FFE_0000, "R10", v, 32'h7FFE_0000);
    cyc(32'h100, 0, 1, 0, cpu_a(2, 1), 32'hFFFF_FFFF);
    cyc(32'h100, 0, 1, 0, cpu_a(1, 1), 32'hFFFF_FFFF);
    check_all("R10");

    // R7 target moves to 2 (6 & 3)
    cyc(32'h100, 0, 1, 1, sys_a(4), 32'h6);
    cyc(32'h500, 0);
    check_all("R7");
    rd(0, cpu_a(2, 0), v); chk(v == 32'h800, "R7", v, 32'h800);
    chk(lvl(0) == 16'h0, "R9", 32'(lvl(0)), 0);
    chk(lvl(2) == 16'h0A00, "R9", 32'(lvl(2)), 32'h0A00);

    // R8 global disable
    cyc(32'h500, 0, 1, 1, sys_a(3), 32'h8000_0000);
    check_all("R8");
    chk(lvl(2) == 16'h0, "R8", 32'(lvl(2)), 0);
    rd(1, sys_a(1), v); chk(v == 32'h8000_0000, "R8", v, 32'h8000_0000);
    cyc(32'h500, 0, 1, 1, sys_a(2), 32'h8000_0000);
    check_all("R8");
    chk(lvl(2) == 16'h0A00, "R8", 32'(lvl(2)), 32'h0A00);

    // R6 per-source disable clears pending and blocks a fresh edge
    cyc(32'h500, 0, 1, 1, sys_a(3), 32'h400);
    check_all("R6");
    chk(lvl(2) == 16'h0200, "R6", 32'(lvl(2)), 32'h0200);
    cyc(32'h100, 0);
    cyc(32'h500, 0);
    check_all("R6");
    chk(lvl(2) == 16'h0200, "R6", 32'(lvl(2)), 32'h0200);
    cyc(32'h500, 0, 1, 1, sys_a(2), 32'h400);
    check_all("R6");
    chk(lvl(2) == 16'h0A00, "R6", 32'(lvl(2)), 32'h0A00);

    // R5 reserved source bit 0 never routes
    cyc(32'h501, 0);
    cyc(32'h501, 0, 1, 1, sys_a(2), 32'hFFFF_FFFF);
    check_all("R5");
    rd(1, sys_a(1), v); chk(v == 0, "R5", v, 0);
    chk(lvl(2) == 16'h0A00, "R5", 32'(lvl(2)), 32'h0A00);

    // R4 bit 31 hidden on readback, unused indices read zero
    cyc(32'h8000_0501, 0);
    check_all("R4");
    rd(1, sys_a(0), v); chk(v == 32'h501, "R4", v, 32'h501);
    rd(1, sys_a(5), v); chk(v == 0, "R4", v, 0);
    rd(0, cpu_a(1, 3), v); chk(v == 0, "R4", v, 0);
    chk(lvl(2) == 16'h0A04, "R4", 32'(lvl(2)), 32'h0A04);

    // R3 timer on cpu3
    cyc(32'h8000_0501, 4'b1000);
    check_all("R3");
    rd(0, cpu_a(3, 0), v); chk(v == 32'h20, "R3", v, 32'h20);
    chk(lvl(2) == 16'h0A24, "R3", 32'(lvl(2)), 32'h0A24);
    cyc(32'h8000_0501, 4'b0000);
    check_all("R3");
    rd(0, cpu_a(3, 0), v); chk(v == 0, "R3", v, 0);

    // R13 line rise and disable write in one clock: write wins
    cyc(32'h8000_1501, 0, 1, 1, sys_a(3), 32'h1000);
    check_all("R13");
    rd(1, sys_a(0), v); chk(v[12] == 1'b0, "R13", v, v & ~32'h1000);

    // random mix against the reference model
    for (int k = 0; k < 400; k++) begin
      int idx, c;
      bit w, ws;
      logic [31:0] d;
      logic [AW-1:0] a;
      e  = m_ext ^ ($urandom & $urandom & $urandom);
      t  = m_tmr ^ NC'($urandom & $urandom);
      w  = ($urandom % 3) != 0;
      ws = $urandom % 2;
      idx = $urandom % 5;
      c  = $urandom % NC;
      d  = $urandom;
      if (ws && idx == 3) d = d & $urandom & $urandom;
      a  = ws ? sys_a(idx) : cpu_a(c, idx % 3);
      cyc(e, t, w, ws, a, d);
      check_all("R9");
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule